// File: doc/BRIEF.md
# Periodic RTC Interrupt Generator

This block turns the timebase strobes of a real-time clock into periodic interrupt requests for an interrupt controller. A two-bit period field picks one of four strobe sources (64 Hz, once a second, once a minute, once an hour). Each selected strobe sets a sticky status flag. The flag stays set until software writes 1 to it. The request output is the flag gated by an enable bit. It is signalled either as a held level or as a one-cycle pulse.

The block also watches a `clk_run_i` input, which reports whether the bus clock is being delivered. If a strobe arrives while that clock is reported stopped, the block falls back to level signalling, even in pulse mode. It holds the request until the clock is reported running again, so a sleeping system cannot miss the event.

The mode and status registers are not reset. Their power-on contents are arbitrary, and in this model they come from the parameters `INIT_MODE` and `INIT_STATUS`. Only the output tracking state is reset. All pins are plain control and status signals; there is no streaming interface.

Top module: `rtc_irq_gen`

## Requirements
- R1: `tick_i` bit k is the strobe for period code k: code 2'b00 means 64 Hz (bit 0), 2'b01 means 1 s (bit 1), 2'b10 means 1 min (bit 2) and 2'b11 means 1 h (bit 3). A strobe on any bit that is not selected leaves the status flag unchanged.
- R2: The mode register is written when `wr_en_i`=1 and `wr_sel_i`=0. Its bits [3:2] hold the period code, bit 1 holds the trigger mode (1 = level, 0 = pulse) and bit 0 holds the enable. The written value appears on `mode_o` in the cycle after the write.
- R3: A selected strobe sets the status flag whatever the enable bit is. The flag shows on `status_o` in the cycle after the strobe.
- R4: A status write (`wr_sel_i`=1) with `wr_data_i[0]`=1 clears the flag in the next cycle. A status write with `wr_data_i[0]`=0 has no effect, and hardware never clears the flag.
- R5: If a selected strobe and a clearing write happen in the same cycle, the flag ends up set.
- R6: In level mode, `irq_o` is high in exactly those cycles in which the flag and the enable are both 1.
- R7: In pulse mode with the bus clock running, `irq_o` is high for a single cycle each time (flag AND enable) goes from 0 to 1. It stays low while that product remains 1.
- R8: With the enable at 0, `irq_o` is low. Enabling again while the flag is still set raises the request again.
- R9: A selected strobe while `clk_run_i`=0 holds `irq_o` at (flag AND enable) from the next cycle, even in pulse mode. The hold lasts until the first clock edge at which `clk_run_i`=1. After that, no extra pulse follows.
- R10: The mode and status registers take their values from `INIT_MODE` and `INIT_STATUS`, and `rst_ni` does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the output tracking state |
| clk_run_i | input | 1 | 1 when the bus clock is being delivered |
| tick_i | input | 4 | Single-cycle timebase strobes, one bit per period code |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = mode, 1 = status |
| wr_data_i | input | 4 | Write data |
| mode_o | output | 4 | Mode register contents |
| status_o | output | 1 | Status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Every register update (mode, flag, hold state) takes one clock edge. The bench therefore drives each stimulus just after an edge and samples one edge later. In level mode, `irq_o` follows the flag and enable in that same sampled cycle. A pulse lasts one cycle, so the cycle after it is also sampled and must read 0. For the stopped-clock fallback, the bench checks the held request in several consecutive cycles, then checks that it drops right after the first edge at which `clk_run_i` is high.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int PERIOD_W = 2;
  localparam int N_TICK   = 1 << PERIOD_W;
  localparam int MODE_W   = PERIOD_W + 2;

  typedef enum logic [PERIOD_W-1:0] {
    PER_64HZ = 2'b00,
    PER_SEC  = 2'b01,
    PER_MIN  = 2'b10,
    PER_HOUR = 2'b11
  } period_e;

  typedef struct packed {
    period_e period;
    logic    trig_level;
    logic    enable;
  } mode_t;

  localparam logic SEL_MODE   = 1'b0;
  localparam logic SEL_STATUS = 1'b1;
endpackage

// File: rtl/rtc_irq_tick_sel.sv
module rtc_irq_tick_sel #(
  parameter int N_TICK = 4,
  localparam int SEL_W = $clog2(N_TICK)
) (
  input  logic [N_TICK-1:0] tick_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              cause_o
);
  logic [N_TICK-1:0] hit;

  for (genvar g = 0; g < N_TICK; g++) begin : g_src
    assign hit[g] = tick_i[g] & (sel_i == SEL_W'(g));
  end

  assign cause_o = |hit;
endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
  import rtc_irq_pkg::*;
#(
  parameter logic [MODE_W-1:0] INIT_MODE   = '0,
  parameter logic              INIT_STATUS = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [MODE_W-1:0] wr_data_i,
  output mode_t             mode_o,
  output logic              flag_o
);
  // Neither register has a reset: contents come from power-up only.
  logic [MODE_W-1:0] mode_q = INIT_MODE;
  logic              flag_q = INIT_STATUS;
  logic              clr;

  assign clr = wr_en_i && (wr_sel_i == SEL_STATUS) && wr_data_i[0];

  always_ff @(posedge clk_i) begin
    if (wr_en_i && (wr_sel_i == SEL_MODE)) mode_q <= wr_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (set_i)    flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign mode_o = mode_t'(mode_q);
  assign flag_o = flag_q;

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !set_i) |=> !flag_o);
  assert_no_hw_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr) |=> (flag_o == $past(flag_o)));
endmodule

// File: rtl/rtc_irq_out.sv
module rtc_irq_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_run_i,
  input  logic cause_i,
  input  logic flag_i,
  input  logic en_i,
  input  logic trig_level_i,
  output logic irq_o
);
  logic act, prev_q, held_q;

  assign act = flag_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      prev_q <= act;
      if (clk_run_i)    held_q <= 1'b0;
      else if (cause_i) held_q <= 1'b1;
    end
  end

  assign irq_o = (trig_level_i | held_q) ? act : (act & ~prev_q);

  assert_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_o);
  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_level_i && !held_q && clk_run_i && irq_o) |=> (!irq_o || trig_level_i));
  assert_hold_stopped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i && !clk_run_i) |=> (irq_o == (flag_i && en_i)));
endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen
  import rtc_irq_pkg::*;
#(
  parameter logic [MODE_W-1:0] INIT_MODE   = '0,
  parameter logic              INIT_STATUS = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_run_i,
  input  logic [N_TICK-1:0] tick_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [MODE_W-1:0] wr_data_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              status_o,
  output logic              irq_o
);
  mode_t mode;
  logic  cause, flag;

  rtc_irq_tick_sel #(.N_TICK(N_TICK)) u_sel (
    .tick_i (tick_i),
    .sel_i  (mode.period),
    .cause_o(cause)
  );

  rtc_irq_regs #(.INIT_MODE(INIT_MODE), .INIT_STATUS(INIT_STATUS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (cause),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .mode_o   (mode),
    .flag_o   (flag)
  );

  rtc_irq_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clk_run_i   (clk_run_i),
    .cause_i     (cause),
    .flag_i      (flag),
    .en_i        (mode.enable),
    .trig_level_i(mode.trig_level),
    .irq_o       (irq_o)
  );

  assign mode_o   = mode;
  assign status_o = flag;
endmodule

// File: tb/rtc_irq_gen_tb.sv
module rtc_irq_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_run = 1'b1;
  logic [3:0] tick = '0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [3:0] wr_data = '0;
  logic [3:0] mode;
  logic       status, irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rtc_irq_gen #(.INIT_MODE(4'b0110), .INIT_STATUS(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clk_run_i(clk_run), .tick_i(tick),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .mode_o(mode), .status_o(status), .irq_o(irq)
  );

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic sel, input logic [3:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic strobe(input int b);
    tick[b] = 1'b1;
    step();
    tick = '0;
  endtask

  task automatic t_reset();
    chk(mode, 4'b0110, "R10 mode preload");
    chk({3'b0, status}, 4'd1, "R10 status preload");
    chk({3'b0, irq}, 4'd0, "R8 disabled after reset");
  endtask

  task automatic t_period();
    for (int s = 0; s < 4; s++) begin
      wr(1'b0, {s[1:0], 2'b10});
      chk(mode, {s[1:0], 2'b10}, "R2 mode readback");
      wr(1'b1, 4'b0001);
      chk({3'b0, status}, 4'd0, "R4 clear");
      strobe((s + 1) % 4);
      chk({3'b0, status}, 4'd0, "R1 unselected strobe ignored");
      strobe(s);
      chk({3'b0, status}, 4'd1, "R1 R3 selected strobe sets flag");
      chk({3'b0, irq}, 4'd0, "R8 no request when disabled");
    end
  endtask

  task automatic t_clear();
    wr(1'b1, 4'b1110);
    chk({3'b0, status}, 4'd1, "R4 write 0 no effect");
    wr(1'b1, 4'b0001);
    chk({3'b0, status}, 4'd0, "R4 write 1 clears");
    wr(1'b0, 4'b0010);
    tick[0] = 1'b1;
    wr(1'b1, 4'b0001);
    tick = '0;
    chk({3'b0, status}, 4'd1, "R5 set beats clear");
    wr(1'b1, 4'b0001);
  endtask

  task automatic t_level();
    wr(1'b0, 4'b0011);
    strobe(0);
    for (int i = 0; i < 3; i++) begin
      chk({3'b0, irq}, 4'd1, "R6 level held");
      step();
    end
    wr(1'b1, 4'b0001);
    chk({3'b0, irq}, 4'd0, "R6 level drops on clear");
  endtask

  task automatic t_edge();
    wr(1'b0, 4'b0001);
    step();
    strobe(0);
    chk({3'b0, irq}, 4'd1, "R7 pulse");
    for (int i = 0; i < 3; i++) begin
      step();
      chk({3'b0, irq}, 4'd0, "R7 single pulse");
    end
    wr(1'b0, 4'b0000);
    chk({3'b0, irq}, 4'd0, "R8 disabled");
    step();
    wr(1'b0, 4'b0001);
    chk({3'b0, irq}, 4'd1, "R8 re-enable re-asserts");
    step();
    chk({3'b0, irq}, 4'd0, "R7 re-enable pulse is one cycle");
  endtask

  task automatic t_stop();
    wr(1'b1, 4'b0001);
    step();
    clk_run = 1'b0;
    strobe(0);
    for (int i = 0; i < 3; i++) begin
      chk({3'b0, irq}, 4'd1, "R9 held while clock stopped");
      step();
    end
    clk_run = 1'b1;
    step();
    chk({3'b0, irq}, 4'd0, "R9 released after clock resumes");
    step();
    chk({3'b0, irq}, 4'd0, "R9 no extra pulse");
  endtask

  task automatic t_rst_keep();
    wr(1'b0, 4'b1011);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    chk(mode, 4'b1011, "R10 mode kept through reset");
    chk({3'b0, status}, 4'd1, "R10 status kept through reset");
  endtask

  initial begin
    repeat (2) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_period();
    t_clear();
    t_level();
    t_edge();
    t_stop();
    t_rst_keep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule